// File: doc/BRIEF.md
# Serial DAC command interface

This block is the digital front end of a single-channel voltage-output DAC. A three-wire serial slave receives fixed-length command frames. The three wires are an active-low chip select, a serial clock and a data input. The block decodes a two-bit opcode and holds the DAC code register and the output-state register. It drives the parallel code, a two-bit output-state encoding and a one-cycle update strobe towards the analog section.

The serial pins are sampled in the system clock domain through two-flop synchronizers. A frame takes effect only on its exact final falling clock edge, so a frame that chip select cuts short leaves no trace. A power-down command selects one of three output terminations and keeps the stored code. A write-through command leaves power-down and loads a new code. An active-low asynchronous clear zeroes the code and aborts any frame in flight. The parameter `CODE_W` selects the variant: 16 gives a 24-bit frame, and 14 gives a 16-bit frame.

Top module: `serial_dac_ctrl`

## Requirements
- R1: After reset, code_o is 0, pd_mode_o is 00 (normal output) and update_o is low.
- R2: Bits are taken MSB first on each falling edge of sclk_i while cs_ni is low, and a frame is FRAME_W bits long (24 when CODE_W is 16, 16 when CODE_W is 14). The top two frame bits are the opcode. Opcode 01 (write-through) loads code_o from frame bits [FRAME_W-3 -: CODE_W], ignores any lower bits and sets pd_mode_o to 00, including when the block is powered down.
- R3: Opcode 10 with frame bit FRAME_W-3 at 0 loads pd_mode_o from frame bits [FRAME_W-5 -: 2] and leaves code_o unchanged. The pd_mode_o encoding is: 00 normal, 01 high impedance, 10 grounded through 100 kilohm, 11 grounded through 1 kilohm.
- R4: Opcode 00, opcode 11, and opcode 10 with frame bit FRAME_W-3 at 1 change neither code_o nor pd_mode_o.
- R5: If cs_ni rises before the FRAME_W-th falling sclk edge, the frame is discarded with no effect.
- R6: Falling sclk edges after the final frame bit are ignored until cs_ni goes high.
- R7: clr_ni low zeroes code_o at once, without a clock, and aborts any partial frame. pd_mode_o is kept. A frame whose cs_ni fall happens while clr_ni is low never starts, and a clear that coincides with a final edge wins.
- R8: update_o is a one-cycle pulse that comes with the new values for each committed write-through or valid power-down command, and for nothing else.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| clr_ni | input | 1 | Active-low asynchronous clear |
| cs_ni | input | 1 | Serial chip select, active low |
| sclk_i | input | 1 | Serial clock; data is taken on its falling edge |
| sdi_i | input | 1 | Serial data in |
| code_o | output | CODE_W | DAC code |
| pd_mode_o | output | 2 | Output state: 00 normal, 01 hi-Z, 10 100k to ground, 11 1k to ground |
| update_o | output | 1 | One-cycle strobe that comes with a new code or mode |

## Verification
A clear and a command commit can fall in the same cycle. The bench provokes this by driving clr_ni low together with the final falling sclk edge of a write-through frame. After that the code must read zero and no update pulse may appear. The bench also holds chip select low across a clear and clocks a full frame after the clear is released. That frame must not be accepted, because its start was lost during the clear.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  typedef enum logic [1:0] {
    OP_NOP   = 2'b00,
    OP_WRITE = 2'b01,
    OP_PWRDN = 2'b10,
    OP_RSVD  = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    PD_NORMAL = 2'b00,
    PD_HIZ    = 2'b01,
    PD_R100K  = 2'b10,
    PD_R1K    = 2'b11
  } pd_e;

  function automatic int frame_len(input int code_w);
    return (code_w == 16) ? 24 : 16;
  endfunction
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/sdac_shifter.sv
module sdac_shifter #(
  parameter int FRAME_W = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_ni,
  input  logic               cs_n_i,
  input  logic               sclk_i,
  input  logic               sdi_i,
  output logic               done_o,
  output logic [FRAME_W-1:0] frame_o
);
  localparam int CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic             cs_q, sclk_q;
  logic             active_q, done_q;
  logic [CNT_W-1:0] cnt_q;
  logic [FRAME_W-1:0] sh_q;
  logic             cs_fall, sclk_fall;

  // edge history follows the pins even during clear, so a start lost to clear stays lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q   <= 1'b1;
      sclk_q <= 1'b1;
    end else begin
      cs_q   <= cs_n_i;
      sclk_q <= sclk_i;
    end
  end

  assign cs_fall   = cs_q & ~cs_n_i;
  assign sclk_fall = sclk_q & ~sclk_i;

  always_ff @(posedge clk_i or negedge rst_ni or negedge clr_ni) begin
    if (!rst_ni || !clr_ni) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      cnt_q    <= '0;
      sh_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (cs_n_i) begin
        active_q <= 1'b0;
      end else if (cs_fall) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
        sh_q     <= '0;
      end else if (active_q && sclk_fall) begin
        sh_q <= {sh_q[FRAME_W-2:0], sdi_i};
        if (cnt_q == LAST) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign done_o  = done_q;
  assign frame_o = sh_q;

  // R6
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !clr_ni)
    cnt_q <= LAST);

  // R5
  cut_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !clr_ni)
    cs_n_i |=> !done_q);
endmodule

// File: rtl/sdac_regs.sv
module sdac_regs
  import sdac_pkg::*;
#(
  parameter int FRAME_W = 24,
  parameter int CODE_W  = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_ni,
  input  logic               done_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic [CODE_W-1:0]  code_o,
  output pd_e                mode_o,
  output logic               update_o
);
  op_e               op;
  logic              guard;
  logic [1:0]        pd_sel;
  logic [CODE_W-1:0] code_fld;
  logic              do_write, do_pd;
  logic [CODE_W-1:0] code_q;
  pd_e               mode_q;
  logic              upd_q;

  assign op       = op_e'(frame_i[FRAME_W-1 -: 2]);
  assign guard    = frame_i[FRAME_W-3];
  assign pd_sel   = frame_i[FRAME_W-5 -: 2];
  assign code_fld = frame_i[FRAME_W-3 -: CODE_W];
  assign do_write = done_i && (op == OP_WRITE);
  assign do_pd    = done_i && (op == OP_PWRDN) && !guard;

  always_ff @(posedge clk_i or negedge rst_ni or negedge clr_ni) begin
    if (!rst_ni || !clr_ni) begin
      code_q <= '0;
      upd_q  <= 1'b0;
    end else begin
      upd_q <= do_write || do_pd;
      if (do_write) code_q <= code_fld;
    end
  end

  // mode survives clear; only reset or a command moves it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= PD_NORMAL;
    end else if (do_write) begin
      mode_q <= PD_NORMAL;
    end else if (do_pd) begin
      mode_q <= pd_e'(pd_sel);
    end
  end

  assign code_o   = code_q;
  assign mode_o   = mode_q;
  assign update_o = upd_q;

  // R4
  no_effect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !clr_ni)
    done_i && (op == OP_NOP || op == OP_RSVD) |=> $stable(code_q) && $stable(mode_q) && !upd_q);

  // R3
  pd_keep_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !clr_ni)
    done_i && op == OP_PWRDN |=> $stable(code_q));

  // R2
  write_wakes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !clr_ni)
    done_i && op == OP_WRITE |=> mode_q == PD_NORMAL && upd_q);

  // R8
  upd_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !clr_ni)
    upd_q |=> !upd_q);
endmodule

// File: rtl/serial_dac_ctrl.sv
module serial_dac_ctrl
  import sdac_pkg::*;
#(
  parameter int CODE_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic [CODE_W-1:0] code_o,
  output logic [1:0]        pd_mode_o,
  output logic              update_o
);
  localparam int FRAME_W = frame_len(CODE_W);

  logic [2:0]         pins_s;
  logic               done;
  logic [FRAME_W-1:0] frame;
  pd_e                mode;

  sdac_sync #(.W(3), .RST_VAL(3'b110)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({cs_ni, sclk_i, sdi_i}),
    .q_o    (pins_s)
  );

  sdac_shifter #(.FRAME_W(FRAME_W)) i_shifter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_ni  (clr_ni),
    .cs_n_i  (pins_s[2]),
    .sclk_i  (pins_s[1]),
    .sdi_i   (pins_s[0]),
    .done_o  (done),
    .frame_o (frame)
  );

  sdac_regs #(.FRAME_W(FRAME_W), .CODE_W(CODE_W)) i_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_ni   (clr_ni),
    .done_i   (done),
    .frame_i  (frame),
    .code_o   (code_o),
    .mode_o   (mode),
    .update_o (update_o)
  );

  assign pd_mode_o = mode;

  // R7
  clear_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |-> code_o == '0 && !update_o);
endmodule

// File: tb/test_serial_dac_ctrl.sv
`timescale 1ns/1ps
module test_serial_dac_ctrl;
  localparam int CODE_W  = 16;
  localparam int FRAME_W = 24;

  logic clk = 1'b0;
  logic rst_ni = 1'b0, clr_ni = 1'b1, cs_ni = 1'b1, sclk_i = 1'b1, sdi_i = 1'b0;
  logic [CODE_W-1:0] code_o;
  logic [1:0] pd_mode_o;
  logic update_o;

  int checks = 0, failures = 0, upd_cnt = 0, exp_upd = 0;
  logic [CODE_W-1:0] exp_code = '0;
  logic [1:0] exp_mode = 2'b00;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  serial_dac_ctrl #(.CODE_W(CODE_W)) i_serial_dac_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .clr_ni(clr_ni), .cs_ni(cs_ni),
    .sclk_i(sclk_i), .sdi_i(sdi_i), .code_o(code_o),
    .pd_mode_o(pd_mode_o), .update_o(update_o)
  );

  always @(negedge clk) if (update_o) upd_cnt++;

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic chk_state(input string tag);
    chk({tag, " code"}, 32'(code_o), 32'(exp_code));
    chk({tag, " mode"}, 32'(pd_mode_o), 32'(exp_mode));
    chk({tag, " upd"}, 32'(upd_cnt), 32'(exp_upd));
  endtask

  function automatic logic [23:0] mk_wr(input logic [15:0] c, input logic [5:0] low);
    return {2'b01, c, low};
  endfunction

  function automatic logic [23:0] mk_pd(input logic [1:0] m, input logic g, input logic [18:0] junk);
    return {2'b10, g, junk[18], m, junk[17:0]};
  endfunction

  // reference model, applied only to full frames
  task automatic model(input logic [23:0] f);
    case (f[23:22])
      2'b01: begin exp_code = f[21:6]; exp_mode = 2'b00; exp_upd++; end
      2'b10: if (!f[21]) begin exp_mode = f[19:18]; exp_upd++; end
      default: ;
    endcase
  endtask

  task automatic clock_bit(input logic b);
    sdi_i = b;  wait_clk(3);
    sclk_i = 1'b0; wait_clk(4);
    sclk_i = 1'b1; wait_clk(3);
  endtask

  task automatic send(input logic [23:0] f, input int nbits, input int extra);
    cs_ni = 1'b0; wait_clk(4);
    for (int i = 0; i < nbits; i++) clock_bit(f[23-i]);
    for (int i = 0; i < extra; i++) clock_bit(1'($urandom));
    cs_ni = 1'b1; wait_clk(10);
    if (nbits == FRAME_W) model(f);
  endtask

  initial begin
    void'($urandom(32'd4242));
    wait_clk(5);
    // R1 reset state
    chk("R1 reset code", 32'(code_o), 0);
    chk("R1 reset mode", 32'(pd_mode_o), 0);
    chk("R1 reset update", 32'(update_o), 0);
    rst_ni = 1'b1; wait_clk(5);
    chk_state("R1 after release");

    // R2 write-through, low bits ignored
    send(mk_wr(16'hA5C3, 6'h3F), 24, 0);
    chk_state("R2 write A5C3");
    send(mk_wr(16'h0001, 6'h15), 24, 0);
    chk_state("R2 write 0001");

    // R3 each power-down mode keeps the code
    send(mk_pd(2'b01, 1'b0, 19'h7FFFF), 24, 0);
    chk_state("R3 pd hiz");
    send(mk_pd(2'b10, 1'b0, 19'h0), 24, 0);
    chk_state("R3 pd 100k");
    send(mk_pd(2'b11, 1'b0, 19'h12345), 24, 0);
    chk_state("R3 pd 1k");
    send(mk_pd(2'b00, 1'b0, 19'h0), 24, 0);
    chk_state("R3 pd restore");

    // R2 write while powered down wakes the output
    send(mk_pd(2'b10, 1'b0, 19'h0), 24, 0);
    send(mk_wr(16'hFFFF, 6'h0), 24, 0);
    chk_state("R2 write in pd");

    // R4 nop, reserved, power-down with guard bit set
    send({2'b00, 22'h3FFFFF}, 24, 0);
    chk_state("R4 nop");
    send({2'b11, 22'h155555}, 24, 0);
    chk_state("R4 reserved");
    send(mk_pd(2'b11, 1'b1, 19'h0), 24, 0);
    chk_state("R4 pd guard set");

    // R5 truncated frames
    send(mk_wr(16'h1234, 6'h0), 23, 0);
    chk_state("R5 cut at 23");
    send(mk_pd(2'b01, 1'b0, 19'h0), 5, 0);
    chk_state("R5 cut at 5");

    // R6 extra edges after the final bit
    send(mk_wr(16'h2468, 6'h0), 24, 7);
    chk_state("R6 extra edges");

    // R7 clear mid-frame, mode kept, frame start lost during clear
    send(mk_pd(2'b10, 1'b0, 19'h0), 24, 0);
    begin
      logic [23:0] f = mk_wr(16'h5A5A, 6'h0);
      cs_ni = 1'b0; wait_clk(4);
      for (int i = 0; i < 10; i++) clock_bit(f[23-i]);
      clr_ni = 1'b0; #1;
      chk("R7 async zero", 32'(code_o), 0);
      exp_code = '0;
      for (int i = 10; i < 24; i++) clock_bit(f[23-i]);
      clr_ni = 1'b1; wait_clk(4);
      for (int i = 0; i < 24; i++) clock_bit(f[23-i]);
      cs_ni = 1'b1; wait_clk(10);
    end
    chk_state("R7 clear abort");

    // R7 clear coincides with the final edge: clear wins
    send(mk_wr(16'h7777, 6'h0), 24, 0);
    begin
      logic [23:0] f = mk_wr(16'hBEEF, 6'h0);
      cs_ni = 1'b0; wait_clk(4);
      for (int i = 0; i < 23; i++) clock_bit(f[23-i]);
      sdi_i = f[0]; wait_clk(3);
      sclk_i = 1'b0; clr_ni = 1'b0; wait_clk(4);
      sclk_i = 1'b1; wait_clk(3);
      clr_ni = 1'b1; cs_ni = 1'b1; wait_clk(10);
      exp_code = '0;
    end
    chk_state("R7 clear vs commit");

    // R8 random traffic, update count tracked in chk_state
    for (int n = 0; n < 60; n++) begin
      logic [23:0] f = 24'($urandom);
      int nb = (($urandom % 5) == 0) ? int'($urandom % 23) + 1 : 24;
      int ex = (($urandom % 4) == 0) ? int'($urandom % 3) + 1 : 0;
      send(f, nb, ex);
      chk_state("R8 random");
    end

    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule